// File: doc/BRIEF.md
# Serial Successive-Approximation ADC Device Model

This block plays the part of an eight-channel, 12-bit serial converter so that a serial-port controller can be exercised in logic against a predictable partner. The controller pulls an active-low select, toggles a serial clock that idles high, and shifts a channel address in on the data input. The model answers on its data output. Each frame starts with four zero bits, and the 12-bit sample of the selected channel follows, most significant bit first. Eight parallel 12-bit inputs stand in for the analog voltages.

A frame is sixteen serial clocks. The address that arrives during one frame picks the channel for the frame after it. The first frame after select falls always converts channel 0. Frames follow one another with no gap for as long as select stays low. The model runs entirely on a fast system clock: it synchronises the serial pins and finds the serial clock edges by comparing successive samples.

Top module: `sar_adc_emu`

## Requirements
- R1: After reset the data output is 0.
- R2: While select is high the data output is 0. Raising select in mid-frame abandons that frame, and the next frame starts again at bit 1 on channel 0.
- R3: On falling edges 1, 2, 3 and 4 of each frame (edges counted from 1 after select falls, modulo 16), the data output goes to 0.
- R4: On falling edge k for k from 5 to 16, the data output carries bit 16-k of the sample: bit 11 first, bit 0 last, straight binary.
- R5: The 3-bit address is sampled from the data input on rising edges 3, 4 and 5, most significant bit first. It selects the channel converted in the following frame.
- R6: The first frame after select falls converts channel 0, whatever address came before.
- R7: The sample is taken from the selected parallel input at falling edge 4. Changes on that input later in the frame do not alter the bits shifted out.
- R8: While select stays low, frames run back to back every 16 serial clocks, and the next frame's falling edge 1 follows rising edge 16 directly.
- R9: Data-input values present on rising edges other than 3, 4 and 5 have no effect on the channel selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; serial pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select from the controller |
| sclk | input | 1 | Serial clock from the controller, idle high |
| din | input | 1 | Serial address input |
| ch_values | input | NUM_CH*RES_W (96) | Packed channel values; channel n occupies bits n*12+11 down to n*12 |
| dout | output | 1 | Serial result output |

## Verification
The bench targets the one-frame delay of the address. A model that converted the address at once would return the wrong channel's value on every frame. The bench also drives random data on every non-address edge, so a model that samples the address one edge early or late picks up garbage bits. In one frame the selected channel's value is changed after edge 4. A model that reads the input live instead of holding a captured sample would then show mixed bits. A frame is aborted halfway and a new session follows. A model that kept its bit counter or its channel across select high would shift the leading zeros out of place, or convert the aborted frame's address instead of channel 0. Runs of continuous frames at all-zero, all-one and mid-scale values catch counters that fail to wrap at 16.

// File: rtl/saremu_pkg.sv
// Package: types shared by the serial converter model.
// Assumes: nothing beyond IEEE 1800-2017.
package saremu_pkg;

    // One fast-clock view of the synchronised serial pins.
    typedef struct packed {
        logic active;   // select asserted (low on the pin)
        logic rise;     // serial clock rose this cycle
        logic fall;     // serial clock fell this cycle
        logic data;     // synchronised data input
    } ser_evt_t;

endpackage

// File: rtl/saremu_sync.sv
// Module: multi-stage synchroniser for one asynchronous pin.
// Assumes: STAGES >= 2; RST_VAL is the pin's idle level.
module saremu_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    // Shift the pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/saremu_front.sv
// Module: synchronises select, serial clock and data input, and turns the
//         serial clock into one-cycle rise/fall strobes.
// Assumes: the serial clock half period spans several fast clock cycles.
module saremu_front
    import saremu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n,
    input  logic     sclk,
    input  logic     din,
    output ser_evt_t evt
);
    localparam int       NPIN    = 3;
    localparam bit [2:0] RST_PAT = 3'b011; // {din, cs_n, sclk} idle levels

    logic [NPIN-1:0] pin_raw;
    logic [NPIN-1:0] pin_s;
    logic            sclk_d;

    assign pin_raw = {din, cs_n, sclk};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        saremu_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (RST_PAT[g])
        ) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pin_raw[g]),
            .q     (pin_s[g])
        );
    end

    // Keep the previous synchronised serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= pin_s[0];
    end

    // Build the event record from the synchronised pins.
    always_comb begin
        evt.active = ~pin_s[1];
        evt.rise   = pin_s[0] & ~sclk_d;
        evt.fall   = ~pin_s[0] & sclk_d;
        evt.data   = pin_s[2];
    end
endmodule

// File: rtl/saremu_seq.sv
// Module: frame sequencer. Counts rising and falling serial edges inside a
//         frame, collects the address bits and holds the channel for the
//         next frame.
// Assumes: FRAME_LEN > RES_W, NUM_CH a power of two >= 4.
module saremu_seq
    import saremu_pkg::*;
#(
    parameter int FRAME_LEN = 16,
    parameter int RES_W     = 12,
    parameter int NUM_CH    = 8,
    localparam int CNT_W    = $clog2(FRAME_LEN),
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int IDX_W    = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ser_evt_t         evt,
    output logic [CH_W-1:0]  chan,
    output logic             cap_stb,
    output logic             out_stb,
    output logic             lead_bit,
    output logic [IDX_W-1:0] bit_idx
);
    localparam int LEAD    = FRAME_LEN - RES_W;     // leading zero count
    localparam int ADDR_LO = LEAD - CH_W + 1;       // rise count before first addr bit
    localparam int ADDR_HI = LEAD;                  // rise count before last addr bit
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    logic [CNT_W-1:0] rcnt;
    logic [CNT_W-1:0] fcnt;
    logic [CH_W-1:0]  addr_sr;
    logic [CNT_W-1:0] rem;
    logic             addr_win;

    assign addr_win = (rcnt >= CNT_W'(ADDR_LO)) && (rcnt <= CNT_W'(ADDR_HI));

    // Count rising edges, shift in the address, update the channel at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || !evt.active) begin
            rcnt    <= '0;
            addr_sr <= '0;
            chan    <= '0;
        end else if (evt.rise) begin
            rcnt <= (rcnt == LAST) ? '0 : rcnt + 1'b1;
            if (addr_win) addr_sr <= {addr_sr[CH_W-2:0], evt.data};
            if (rcnt == LAST) chan <= addr_sr;
        end
    end

    // Count falling edges inside the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !evt.active) fcnt <= '0;
        else if (evt.fall)         fcnt <= (fcnt == LAST) ? '0 : fcnt + 1'b1;
    end

    // Decode the current falling edge into output controls.
    always_comb begin
        rem      = LAST - fcnt;
        out_stb  = evt.active & evt.fall;
        cap_stb  = out_stb & (fcnt == CNT_W'(LEAD - 1));
        lead_bit = (fcnt < CNT_W'(LEAD));
        bit_idx  = IDX_W'(rem);
    end

    // R5
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.active && !(evt.rise && rcnt == LAST)) |=> $stable(chan));

    // R6
    chan_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt.active |=> (chan == '0));

    // R8
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.active && evt.fall && fcnt == LAST) |=> (fcnt == '0));
endmodule

// File: rtl/saremu_shift.sv
// Module: sample capture and serial output. Holds the sample taken at the
//         end of tracking and drives one result bit per falling edge.
// Assumes: strobes come from saremu_seq on the same fast clock.
module saremu_shift #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 12,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int IDX_W = $clog2(RES_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    active,
    input  logic [NUM_CH*RES_W-1:0] ch_values,
    input  logic [CH_W-1:0]         chan,
    input  logic                    cap_stb,
    input  logic                    out_stb,
    input  logic                    lead_bit,
    input  logic [IDX_W-1:0]        bit_idx,
    output logic                    dout
);
    logic [RES_W-1:0] ch_arr [NUM_CH];
    logic [RES_W-1:0] sample;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign ch_arr[g] = ch_values[g*RES_W +: RES_W];
    end

    // Take the selected channel's value at the end of tracking.
    always_ff @(posedge clk) begin
        if (!rst_n)       sample <= '0;
        else if (cap_stb) sample <= ch_arr[chan];
    end

    // Drive zeros while idle or leading, else the indexed sample bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) dout <= 1'b0;
        else if (out_stb)      dout <= lead_bit ? 1'b0 : sample[bit_idx];
    end

    // R1
    reset_out_chk: assert property (@(posedge clk)
        !rst_n |=> (dout == 1'b0));

    // R2
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (dout == 1'b0));

    // R3
    lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb && lead_bit) |=> (dout == 1'b0));

    // R7
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_stb |=> $stable(sample));
endmodule

// File: rtl/sar_adc_emu.sv
// Module: top of the serial converter device model. Wires the pin front end,
//         the frame sequencer and the output shifter together.
// Assumes: serial clock idles high and runs well below clk/4.
module sar_adc_emu
    import saremu_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int RES_W       = 12,
    parameter int FRAME_LEN   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    sclk,
    input  logic                    din,
    input  logic [NUM_CH*RES_W-1:0] ch_values,
    output logic                    dout
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int IDX_W = $clog2(RES_W);

    ser_evt_t         evt;
    logic [CH_W-1:0]  chan;
    logic             cap_stb;
    logic             out_stb;
    logic             lead_bit;
    logic [IDX_W-1:0] bit_idx;

    saremu_front #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_front (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .din   (din),
        .evt   (evt)
    );

    saremu_seq #(
        .FRAME_LEN (FRAME_LEN),
        .RES_W     (RES_W),
        .NUM_CH    (NUM_CH)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .chan     (chan),
        .cap_stb  (cap_stb),
        .out_stb  (out_stb),
        .lead_bit (lead_bit),
        .bit_idx  (bit_idx)
    );

    saremu_shift #(
        .NUM_CH (NUM_CH),
        .RES_W  (RES_W)
    ) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (evt.active),
        .ch_values (ch_values),
        .chan      (chan),
        .cap_stb   (cap_stb),
        .out_stb   (out_stb),
        .lead_bit  (lead_bit),
        .bit_idx   (bit_idx),
        .dout      (dout)
    );
endmodule

// File: tb/test_sar_adc_emu.sv
// Bench: drives the controller side of the serial port and checks each bit.
module test_sar_adc_emu;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;     // fast clocks per serial half period
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b1;
    logic         din = 1'b0;
    logic [95:0]  ch_values;
    logic         dout;
    logic [11:0]  vals [8];
    logic [2:0]   cur_ch;
    int           total = 0;
    int           bad = 0;
    int           cyc = 0;
    bit           done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) ch_values[i*12 +: 12] = vals[i];
    end

    sar_adc_emu i_sar_adc_emu (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .din       (din),
        .ch_values (ch_values),
        .dout      (dout)
    );

    // Expected output bit on falling edge k of a frame (R3, R4).
    function automatic logic exp_bit(input int k, input logic [11:0] v);
        return (k <= 4) ? 1'b0 : v[16 - k];
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic cs_start();
        cs_n = 1'b0;
        cur_ch = 3'd0;          // R6: first frame converts channel 0
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_stop();
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 idle dout", int'(dout), 0);
    endtask

    // One frame of nedge serial clocks; full frames are checked bit by bit.
    task automatic run_frame(input logic [2:0] addr, input bit perturb,
                             input int nedge, input string tag);
        logic [11:0] expv;
        logic [11:0] word;
        expv = vals[cur_ch];
        word = '0;
        for (int k = 1; k <= nedge; k++) begin
            sclk = 1'b0;
            // R5: address bits present for rising edges 3..5; R9 noise elsewhere
            if (k >= 3 && k <= 5) din = addr[5 - k];
            else                  din = 1'($urandom);
            if (perturb && k == 7) vals[cur_ch] = ~expv;
            repeat (HALF) @(negedge clk);
            if (nedge == 16) begin
                chk((k <= 4) ? "R3 lead" : "R4 bit", int'(dout), int'(exp_bit(k, expv)));
                if (k >= 5) word[16 - k] = dout;
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        if (nedge == 16) begin
            chk(tag, int'(word), int'(expv));
            cur_ch = addr;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=%0d exp=<%0d", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 8; i++) vals[i] = 12'(100 * i + 7);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset dout", int'(dout), 0);

        // Session 1: first frame converts channel 0, address takes effect next frame.
        cs_start();
        run_frame(3'd3, 1'b0, 16, "R6 first frame ch0");
        run_frame(3'd5, 1'b0, 16, "R5 delayed ch3");
        run_frame(3'd7, 1'b0, 16, "R5 delayed ch5");
        // Directed values at the boundaries.
        vals[7] = 12'hFFF;
        vals[0] = 12'h000;
        vals[2] = 12'h800;
        run_frame(3'd0, 1'b0, 16, "R4 all ones ch7");
        run_frame(3'd2, 1'b0, 16, "R4 zero ch0");
        run_frame(3'd4, 1'b0, 16, "R4 midscale ch2");
        // R7: change the held channel after the capture edge.
        run_frame(3'd1, 1'b0, 16, "R8 R9 cont");
        run_frame(3'd6, 1'b1, 16, "R7 sample held");
        // Random continuous frames with noise on non-address edges.
        for (int f = 0; f < 30; f++) begin
            for (int i = 0; i < 8; i++) vals[i] = 12'($urandom);
            run_frame(3'($urandom), 1'b0, 16, "R8 R9 random");
        end
        cs_stop();

        // Session 2: abort mid-frame with address 6 pending, output 1s.
        vals[0] = 12'hFFF;
        vals[6] = 12'h123;
        cs_start();
        run_frame(3'd6, 1'b0, 16, "R6 ch0 ones");
        run_frame(3'd6, 1'b0, 8, "partial");
        cs_stop();

        // Session 3: restart must begin at bit 1 on channel 0.
        vals[0] = 12'hA5C;
        cs_start();
        run_frame(3'd6, 1'b0, 16, "R2 restart ch0");
        run_frame(3'd1, 1'b0, 16, "R5 after restart ch6");
        cs_stop();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule